// File: doc/BRIEF.md
# Serial Hardware Trigger Edge Unit

This block sits beside a serial peripheral and watches one asynchronous trigger pin. A configuration bit chooses whether the rising or the falling transition of that pin counts. The pin is first brought into the local clock domain by a synchronizer chain. A qualifying transition is then found by comparing the newest synchronized sample with the sample taken one cycle earlier.

One edge detector serves both roles of the peripheral. In master mode a qualifying edge becomes a one-cycle start request to the transfer engine, but only when the trigger-enable bit is set and the configuration field selects one of the two serial-interface configurations that use the trigger. In slave mode the same edge becomes a one-cycle pulse on a separate trigger-output pin.

The trigger is intended for multiple-transfer work in the deserial configuration. The enable, mode and polarity inputs are driven by register bits elsewhere in the peripheral.

Top module: `trig_edge_unit`

## Requirements
- R1: While `rst_n` is low, both outputs are low and every synchronizer and previous-sample flop holds 0. A trigger level of 1 held through reset is therefore seen as a rising edge once reset is released.
- R2: With `cfg_pol_fall` = 0, a 0-to-1 transition of `trig_in` is a trigger edge and a 1-to-0 transition is not.
- R3: With `cfg_pol_fall` = 1, a 1-to-0 transition of `trig_in` is a trigger edge and a 0-to-1 transition is not.
- R4: `xfer_start` pulses on a trigger edge when three conditions hold: `cfg_master` = 1, `cfg_trig_en` = 1, and `cfg_mode` is 2'b10 (deserial) or 2'b01 (combined).
- R5: While `cfg_trig_en` = 0, `xfer_start` stays low. An edge seen during that time is not kept, so setting the enable bit later produces no start request.
- R6: When `cfg_mode` is 2'b00 (plain) or 2'b11 (reserved), `xfer_start` stays low.
- R7: With `cfg_master` = 0, every trigger edge gives a `trig_out` pulse whatever `cfg_trig_en` and `cfg_mode` are, and `xfer_start` stays low.
- R8: With `cfg_master` = 1, `trig_out` stays low.
- R9: Changing `cfg_pol_fall` while `trig_in` is steady produces no pulse on either output.
- R10: Timing of each pulse:
  - Each pulse lasts exactly one clock cycle.
  - A pulse is first visible after the third rising clock edge that follows the `trig_in` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous hardware trigger pin |
| cfg_pol_fall | input | 1 | 0 selects the rising edge, 1 selects the falling edge |
| cfg_trig_en | input | 1 | Enables master-mode start requests |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_mode | input | 2 | Configuration: 00 plain, 01 combined, 10 deserial, 11 reserved |
| xfer_start | output | 1 | One-cycle transfer-start request (master mode) |
| trig_out | output | 1 | One-cycle trigger output pulse (slave mode) |

## Verification
On every cycle, the assertions check the gating rules:
- no start request in slave mode, with the enable bit clear, or in an unsupported configuration;
- no output pulse in master mode;
- the detector never reports an edge twice in a row unless the polarity bit has just changed.

Some behaviours are visible only through the bench's scenarios:
- which edge is accepted under each polarity;
- the three-cycle latency;
- that an edge seen while disabled is dropped rather than stored;
- that a polarity flip alone is silent;
- that a level held high through reset is seen as a rising edge.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_COMB  = 2'b01,
        MODE_DSER  = 2'b10,
        MODE_RSVD  = 2'b11
    } xfer_cfg_e;

    typedef struct packed {
        logic start;
        logic pulse;
    } route_st_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES >= 2) begin : g_chain
            always_comb begin
                chain_d = {chain_q[LAST-1:0], din};
            end
        end else begin : g_single
            always_comb begin
                chain_d = din;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/trig_edge.sv
module trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic pol_fall,
    output logic hit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        hit    = pol_fall ? (prev_q & ~lvl) : (lvl & ~prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R10 / R9: an edge is never reported twice in a row unless polarity just moved
    a_r10_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!hit || (pol_fall != $past(pol_fall))));
endmodule

// File: rtl/trig_route.sv
module trig_route
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       master,
    input  logic       trig_en,
    input  xfer_cfg_e  mode,
    output logic       xfer_start,
    output logic       trig_out
);
    route_st_t st_d, st_q;
    logic      mode_ok;

    always_comb begin
        mode_ok     = (mode == MODE_DSER) || (mode == MODE_COMB);
        st_d.start  = hit & master & trig_en & mode_ok;
        st_d.pulse  = hit & ~master;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xfer_start = st_q.start;
    assign trig_out   = st_q.pulse;

    a_r7_slave_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> !xfer_start);
    a_r8_master_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        master |=> !trig_out);
    a_r5_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> !xfer_start);
    a_r6_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PLAIN) || (mode == MODE_RSVD)) |=> !xfer_start);
endmodule

// File: rtl/trig_edge_unit.sv
module trig_edge_unit
    import trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic       cfg_pol_fall,
    input  logic       cfg_trig_en,
    input  logic       cfg_master,
    input  logic [1:0] cfg_mode,
    output logic       xfer_start,
    output logic       trig_out
);
    logic lvl_sync;
    logic edge_hit;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trig_in),
        .dout (lvl_sync)
    );

    trig_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_sync),
        .pol_fall(cfg_pol_fall),
        .hit     (edge_hit)
    );

    trig_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (edge_hit),
        .master    (cfg_master),
        .trig_en   (cfg_trig_en),
        .mode      (xfer_cfg_e'(cfg_mode)),
        .xfer_start(xfer_start),
        .trig_out  (trig_out)
    );

    // R10: the two outputs never pulse together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_start && trig_out));
endmodule

// File: tb/trig_edge_unit_test.sv
module trig_edge_unit_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 11;
    // bits: [8]pol [7]en [6]master [5:4]mode [3]from [2]to [1]exp_start [0]exp_out
    localparam logic [8:0] TBL [NVEC] = '{
        9'b0_1_1_10_0_1_1_0,  // R2 R4 R8 rising accepted, deserial
        9'b0_1_1_10_1_0_0_0,  // R2 falling ignored
        9'b1_1_1_01_1_0_1_0,  // R3 R4 falling accepted, combined
        9'b1_1_1_01_0_1_0_0,  // R3 rising ignored
        9'b0_1_1_01_0_1_1_0,  // R4 combined rising
        9'b0_1_1_00_0_1_0_0,  // R6 plain blocked
        9'b1_1_1_11_1_0_0_0,  // R6 reserved blocked
        9'b0_0_1_10_0_1_0_0,  // R5 enable clear
        9'b0_0_0_00_0_1_0_1,  // R7 slave, en/mode ignored
        9'b1_1_0_10_1_0_0_1,  // R7 slave falling
        9'b1_0_0_11_0_1_0_0   // R7 slave wrong edge
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic       cfg_pol_fall = 1'b0;
    logic       cfg_trig_en = 1'b0;
    logic       cfg_master = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       xfer_start, trig_out;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_edge_unit uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .cfg_pol_fall(cfg_pol_fall), .cfg_trig_en(cfg_trig_en),
        .cfg_master(cfg_master), .cfg_mode(cfg_mode),
        .xfer_start(xfer_start), .trig_out(trig_out)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // after a trig_in change at a negedge: outputs low at negedges 1 and 2,
    // pulse visible at negedge 3, low again at negedge 4 (R10)
    task automatic expect_window(input logic es, input logic eo, input string req);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check(xfer_start, (k == 3) ? es : 1'b0, req, $sformatf("xfer_start cycle %0d", k));
            check(trig_out,   (k == 3) ? eo : 1'b0, req, $sformatf("trig_out cycle %0d", k));
        end
    endtask

    task automatic quiet(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(xfer_start, 1'b0, req, "xfer_start quiet");
            check(trig_out,   1'b0, req, "trig_out quiet");
        end
    endtask

    initial begin
        // R1: trigger held high through reset, master deserial rising
        cfg_master = 1'b1; cfg_trig_en = 1'b1; cfg_mode = 2'b10; trig_in = 1'b1;
        repeat (3) @(negedge clk);
        check(xfer_start, 1'b0, "R1", "xfer_start in reset");
        check(trig_out,   1'b0, "R1", "trig_out in reset");
        rst_n = 1'b1;
        expect_window(1'b1, 1'b0, "R1");

        foreach (TBL[i]) begin
            logic [8:0] v;
            v = TBL[i];
            @(negedge clk);
            cfg_pol_fall = v[8]; cfg_trig_en = v[7]; cfg_master = v[6];
            cfg_mode = v[5:4]; trig_in = v[3];
            repeat (6) @(negedge clk);
            trig_in = v[2];
            expect_window(v[1], v[0], $sformatf("vector %0d", i));
        end

        // R5: edge while disabled is dropped, enabling later gives nothing
        @(negedge clk);
        cfg_master = 1'b1; cfg_mode = 2'b10; cfg_pol_fall = 1'b0; cfg_trig_en = 1'b0; trig_in = 1'b0;
        repeat (6) @(negedge clk);
        trig_in = 1'b1;
        quiet(6, "R5");
        cfg_trig_en = 1'b1;
        quiet(6, "R5");
        trig_in = 1'b0;
        quiet(6, "R5");
        trig_in = 1'b1;
        expect_window(1'b1, 1'b0, "R5");

        // R9: polarity flips with steady input, slave and master
        cfg_master = 1'b0;
        quiet(4, "R9");
        cfg_pol_fall = 1'b1;
        quiet(6, "R9");
        cfg_pol_fall = 1'b0;
        quiet(6, "R9");
        cfg_master = 1'b1; cfg_pol_fall = 1'b1;
        quiet(6, "R9");

        // R10: back-to-back edges each give one single-cycle pulse
        cfg_master = 1'b0; cfg_pol_fall = 1'b0; trig_in = 1'b0;
        repeat (6) @(negedge clk);
        trig_in = 1'b1;
        expect_window(1'b0, 1'b1, "R10");
        trig_in = 1'b0;
        quiet(4, "R10");
        trig_in = 1'b1;
        expect_window(1'b0, 1'b1, "R10");

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check(trig_out, 1'b0, "R1", "trig_out after reset");
        check(xfer_start, 1'b0, "R1", "xfer_start after reset");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule